// File: doc/BRIEF.md
# Temperature Window Compare Flagger

This block sits behind an ADC sequencer and looks at every conversion result that the sequencer reports. Only results tagged with the temperature channel index are considered. Each such result is tested against a programmable window, given as a low bound and a high bound, under one of four comparison modes. When the test passes, a sticky temperature-change flag is raised. Software clears the flag by reading the status register, which is modelled here as a one-cycle clear strobe.

The flag can take the place of the ordinary end-of-conversion event as the interrupt source for the temperature channel. A select input picks which of the two drives the interrupt line. While the sensor is enabled, the most recent accepted temperature result is held in a register that can be read at any time. While the sensor is disabled, temperature-channel results are dropped.

Top module: `tempwin_flagger`

## Requirements
- R1: After reset, `tchg_flag` is 0, `irq` is 0 and `temp_latest` is 0.
- R2: A result with `res_valid`=1, `sens_en`=1 and `res_chan` equal to the temperature channel index (default 7) is stored in `temp_latest` at that clock edge. Results on any other channel leave `temp_latest` unchanged.
- R3: Mode code 0 (below) sets the flag when the value is strictly less than `win_lo`. All comparisons are unsigned on 12 bits.
- R4: Mode code 1 (above) sets the flag when the value is strictly greater than `win_hi`.
- R5: Mode code 2 (inside) sets the flag when `win_lo` <= value <= `win_hi`, with both bounds inclusive.
- R6: Mode code 3 (outside) sets the flag when the value is below `win_lo` or above `win_hi`.
- R7: The flag stays set until `flag_clr` is pulsed. If a set event and `flag_clr` occur in the same cycle, the flag ends up set.
- R8: With `sens_en`=0, temperature-channel results are ignored. The flag is not set, the end-of-conversion event is not raised, and `temp_latest` is unchanged.
- R9: With `irq_sel`=1, `irq` follows `tchg_flag`. With `irq_sel`=0, `irq` follows a sticky end-of-conversion bit that any accepted temperature result sets and that `flag_clr` clears, with set winning over clear.
- R10: Results on channels other than the temperature channel never set the flag, whatever their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | 3 | Channel index of the result |
| res_data | input | 12 | Conversion result value |
| sens_en | input | 1 | Temperature sensor enable |
| win_lo | input | 12 | Window low bound |
| win_hi | input | 12 | Window high bound |
| cmp_mode | input | 2 | Compare mode: 0 below, 1 above, 2 inside, 3 outside |
| irq_sel | input | 1 | 1 = interrupt on temperature change, 0 = on end of conversion |
| flag_clr | input | 1 | Status-read clear strobe |
| tchg_flag | output | 1 | Sticky temperature-change flag |
| irq | output | 1 | Interrupt request |
| temp_latest | output | 12 | Latest accepted temperature result |

## Verification
With the default settings, `temp_latest`, the flag and the end-of-conversion bit each change at the first rising edge at which the result strobe is sampled high. `irq` follows them combinationally in the same cycle. The bench drives every input on a falling edge and lowers the strobe at the next falling edge. It then reads the outputs at that falling edge, half a period after the edge that updated them. Checks that something stayed unchanged are read at the same point, after the ignored result and before any further stimulus.

// File: rtl/tempwin_pkg.sv
package tempwin_pkg;

   typedef enum logic [1:0] {
      CMP_BELOW   = 2'd0,
      CMP_ABOVE   = 2'd1,
      CMP_INSIDE  = 2'd2,
      CMP_OUTSIDE = 2'd3
   } cmp_mode_e;

endpackage

// File: rtl/tempwin_cmp.sv
module tempwin_cmp
   import tempwin_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W-1:0] value,
   input  logic [DATA_W-1:0] lo_bound,
   input  logic [DATA_W-1:0] hi_bound,
   input  cmp_mode_e         mode,
   output logic              hit
);

   logic under_lo;
   logic over_hi;

   assign under_lo = value < lo_bound;
   assign over_hi  = value > hi_bound;

   always_comb begin
      unique case (mode)
         CMP_BELOW:   hit = under_lo;
         CMP_ABOVE:   hit = over_hi;
         CMP_INSIDE:  hit = !under_lo && !over_hi;
         CMP_OUTSIDE: hit = under_lo || over_hi;
         default:     hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/tempwin_sticky.sv
module tempwin_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr_evt,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (set_evt) q <= 1'b1;
      else if (clr_evt) q <= 1'b0;
   end

   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q && !clr_evt |=> q);

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt |=> q);

endmodule

// File: rtl/tempwin_flagger.sv
module tempwin_flagger
   import tempwin_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int CH_W    = 3,
   parameter int TEMP_CH = 7,
   parameter int PIPE    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_valid,
   input  logic [CH_W-1:0]   res_chan,
   input  logic [DATA_W-1:0] res_data,
   input  logic              sens_en,
   input  logic [DATA_W-1:0] win_lo,
   input  logic [DATA_W-1:0] win_hi,
   input  logic [1:0]        cmp_mode,
   input  logic              irq_sel,
   input  logic              flag_clr,
   output logic              tchg_flag,
   output logic              irq,
   output logic [DATA_W-1:0] temp_latest
);

   localparam int NUM_CH = 1 << CH_W;
   localparam logic [CH_W-1:0] TEMP_IDX = CH_W'(TEMP_CH);

   if (DATA_W < 2) begin : g_bad_width
      $error("tempwin_flagger: DATA_W must be at least 2");
   end
   if (TEMP_CH < 0 || TEMP_CH >= NUM_CH) begin : g_bad_chan
      $error("tempwin_flagger: TEMP_CH outside channel range");
   end
   if (PIPE != 0 && PIPE != 1) begin : g_bad_pipe
      $error("tempwin_flagger: PIPE must be 0 or 1");
   end

   logic accept;
   logic win_hit;
   logic tchg_set;
   logic eoc_flag;

   assign accept = res_valid && sens_en && (res_chan == TEMP_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      temp_latest <= '0;
      else if (accept) temp_latest <= res_data;
   end

   tempwin_cmp #(.DATA_W(DATA_W)) u_cmp (
      .value    (res_data),
      .lo_bound (win_lo),
      .hi_bound (win_hi),
      .mode     (cmp_mode_e'(cmp_mode)),
      .hit      (win_hit)
   );

   if (PIPE == 0) begin : g_direct
      assign tchg_set = accept && win_hit;
   end else begin : g_staged
      logic set_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) set_q <= 1'b0;
         else        set_q <= accept && win_hit;
      end
      assign tchg_set = set_q;
   end

   tempwin_sticky u_tchg (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (tchg_set),
      .clr_evt (flag_clr),
      .q       (tchg_flag)
   );

   tempwin_sticky u_eoc (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (accept),
      .clr_evt (flag_clr),
      .q       (eoc_flag)
   );

   assign irq = irq_sel ? tchg_flag : eoc_flag;

   // R2
   latest_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && sens_en && res_chan == TEMP_IDX |=> temp_latest == $past(res_data));

   // R8
   temp_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid && !sens_en |=> $stable(temp_latest));

   if (PIPE == 0) begin : g_src_chk
      // R10
      flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(tchg_flag) |-> $past(res_valid && sens_en && res_chan == TEMP_IDX));
   end else begin : g_src_chk_p
      // R10
      flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(tchg_flag) |-> $past(res_valid && sens_en && res_chan == TEMP_IDX, 2));
   end

endmodule

// File: tb/tempwin_flagger_test.sv
module tempwin_flagger_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0;
   logic [2:0]  res_chan = '0;
   logic [11:0] res_data = '0;
   logic        sens_en = 1'b0;
   logic [11:0] win_lo = '0;
   logic [11:0] win_hi = '0;
   logic [1:0]  cmp_mode = '0;
   logic        irq_sel = 1'b1;
   logic        flag_clr = 1'b0;
   logic        tchg_flag;
   logic        irq;
   logic [11:0] temp_latest;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tempwin_flagger uut (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
      .res_data(res_data), .sens_en(sens_en), .win_lo(win_lo), .win_hi(win_hi),
      .cmp_mode(cmp_mode), .irq_sel(irq_sel), .flag_clr(flag_clr),
      .tchg_flag(tchg_flag), .irq(irq), .temp_latest(temp_latest)
   );

   task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one result, strobe high for one edge; outputs read after that edge
   task automatic send(input logic [2:0] ch, input logic [11:0] d, input logic clr);
      @(negedge clk);
      res_valid = 1'b1; res_chan = ch; res_data = d; flag_clr = clr;
      @(negedge clk);
      res_valid = 1'b0; flag_clr = 1'b0;
   endtask

   task automatic clear();
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
   endtask

   task automatic setup(input logic [1:0] m);
      @(negedge clk);
      win_lo = 12'd100; win_hi = 12'd200; cmp_mode = m; sens_en = 1'b1; irq_sel = 1'b1;
      clear();
   endtask

   // expects flag after one temperature result, then clears
   task automatic probe(input string req, input logic [11:0] d, input logic exp);
      send(3'd7, d, 1'b0);
      check(req, {11'd0, tchg_flag}, {11'd0, exp});
      clear();
   endtask

   task automatic t_reset();
      check("R1 flag", {11'd0, tchg_flag}, 12'd0);
      check("R1 irq", {11'd0, irq}, 12'd0);
      check("R1 latest", temp_latest, 12'd0);
   endtask

   task automatic t_latest();
      setup(2'd0);
      send(3'd7, 12'h123, 1'b0);
      check("R2 latest updated", temp_latest, 12'h123);
      send(3'd2, 12'hABC, 1'b0);
      check("R2 other channel keeps latest", temp_latest, 12'h123);
      send(3'd7, 12'hFFF, 1'b0);
      check("R2 latest max value", temp_latest, 12'hFFF);
   endtask

   task automatic t_below();
      setup(2'd0);
      probe("R3 at low bound", 12'd100, 1'b0);
      probe("R3 just below", 12'd99, 1'b1);
      probe("R3 zero", 12'd0, 1'b1);
      probe("R3 high value", 12'hFFF, 1'b0);
   endtask

   task automatic t_above();
      setup(2'd1);
      probe("R4 at high bound", 12'd200, 1'b0);
      probe("R4 just above", 12'd201, 1'b1);
      probe("R4 max unsigned", 12'hFFF, 1'b1);
      probe("R4 low value", 12'd5, 1'b0);
   endtask

   task automatic t_inside();
      setup(2'd2);
      probe("R5 low bound", 12'd100, 1'b1);
      probe("R5 high bound", 12'd200, 1'b1);
      probe("R5 middle", 12'd150, 1'b1);
      probe("R5 below", 12'd99, 1'b0);
      probe("R5 above", 12'd201, 1'b0);
   endtask

   task automatic t_outside();
      setup(2'd3);
      probe("R6 middle", 12'd150, 1'b0);
      probe("R6 low bound", 12'd100, 1'b0);
      probe("R6 below", 12'd99, 1'b1);
      probe("R6 above", 12'd201, 1'b1);
   endtask

   task automatic t_sticky();
      setup(2'd0);
      send(3'd7, 12'd10, 1'b0);
      send(3'd7, 12'd150, 1'b0);
      check("R7 held after non-match", {11'd0, tchg_flag}, 12'd1);
      clear();
      check("R7 cleared by strobe", {11'd0, tchg_flag}, 12'd0);
      send(3'd7, 12'd10, 1'b1);
      check("R7 set wins over clear", {11'd0, tchg_flag}, 12'd1);
      clear();
   endtask

   task automatic t_disabled();
      setup(2'd0);
      send(3'd7, 12'd150, 1'b0);
      clear();
      sens_en = 1'b0;
      send(3'd7, 12'd20, 1'b0);
      check("R8 flag not set when disabled", {11'd0, tchg_flag}, 12'd0);
      check("R8 latest unchanged when disabled", temp_latest, 12'd150);
      irq_sel = 1'b0;
      send(3'd7, 12'd30, 1'b0);
      check("R8 no end-of-conversion when disabled", {11'd0, irq}, 12'd0);
      irq_sel = 1'b1;
      sens_en = 1'b1;
   endtask

   task automatic t_irq();
      setup(2'd0);
      send(3'd7, 12'd150, 1'b0);
      check("R9 change select, no match", {11'd0, irq}, 12'd0);
      send(3'd7, 12'd50, 1'b0);
      check("R9 change select, match", {11'd0, irq}, 12'd1);
      clear();
      irq_sel = 1'b0;
      send(3'd7, 12'd150, 1'b0);
      check("R9 eoc select, temp result", {11'd0, irq}, 12'd1);
      clear();
      check("R9 eoc cleared", {11'd0, irq}, 12'd0);
      send(3'd3, 12'd150, 1'b0);
      check("R9 eoc select, other channel", {11'd0, irq}, 12'd0);
      send(3'd7, 12'd150, 1'b1);
      check("R9 eoc set wins over clear", {11'd0, irq}, 12'd1);
      clear();
      irq_sel = 1'b1;
   endtask

   task automatic t_other_chan();
      setup(2'd0);
      for (int c = 0; c < 7; c++) begin
         send(c[2:0], 12'd1, 1'b0);
      end
      check("R10 other channels never flag", {11'd0, tchg_flag}, 12'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latest();
      t_below();
      t_above();
      t_inside();
      t_outside();
      t_sticky();
      t_disabled();
      t_irq();
      t_other_chan();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule